// File: doc/BRIEF.md
# Byte-Wide Sampling Converter Read Controller

This block is the host side of a 16-bit successive-approximation converter whose digital interface consists of an active-low chip-select, a read/convert strobe, a byte-select line, a BUSY status line and an 8-bit output port. A conversion is launched either by a one-cycle `start_i` request or, while `free_run_i` is high, automatically at the minimum permitted spacing. The controller drives the convert pulse and waits for BUSY to fall and rise again. It then fetches the upper and lower halves of the result over the byte port and presents the assembled two's-complement word through a valid/ready handshake.

All converter timing rules are expressed as clock-cycle parameters. These rules cover the convert pulse width, the setup of read/convert ahead of chip-select, the bus access delay before a byte is sampled and the minimum distance between conversion starts. Read/convert and chip-select are always back high before BUSY can rise, so a finished conversion never retriggers. A BUSY handshake that does not complete within a bounded number of cycles produces an error pulse and the controller returns to idle.

Top module: `adc_byte_reader`

## Requirements
- R1: A conversion is started by holding `cs_no` and `rc_o` both low for exactly `PULSE_CYC` cycles (default 3 cycles, 60 ns); both are low together at no other time.
- R2: `rc_o` and `byte_sel_o` are driven to their new values at least `SETUP_CYC` cycles before any falling edge of `cs_no`, and `rc_o` does not change in the cycle in which `cs_no` falls.
- R3: From the end of the convert pulse until the next conversion, `cs_no` and `rc_o` are both high whenever `busy_i` rises.
- R4: Two conversion starts (a `cs_no` falling edge while `rc_o` is low) are at least `SPACING_CYC` cycles apart.
- R5: After `busy_i` has risen, the high byte is read first with `byte_sel_o` = 0 (port carries result bits 15..8), then the low byte with `byte_sel_o` = 1 (bits 7..0). Each byte is sampled `ACCESS_CYC` cycles after `cs_no` fell or `byte_sel_o` changed with `cs_no` low.
- R6: `word_o` = {high byte, low byte} is presented with `valid_o` high and held unchanged until a cycle with `valid_o` and `ready_i` both high.
- R7: No conversion starts while a word is pending on `valid_o`; a `start_i` pulse is remembered until a conversion launches.
- R8: If `busy_i` has not fallen and risen again within `TIMEOUT_CYC` cycles after the convert pulse ends, `err_o` is high for exactly one cycle, `TIMEOUT_CYC` cycles after the pulse ended, no word is produced and the controller returns to idle.
- R9: With `CS_SPLIT` = 0, `cs_no` falls once per result and stays low across both byte reads; with `CS_SPLIT` = 1 it returns high for `SETUP_CYC` cycles between the reads and `byte_sel_o` changes only while `cs_no` is high.
- R10: During reset `cs_no` = 1, `rc_o` = 1, `byte_sel_o` = 0, `valid_o` = 0 and `err_o` = 0.
- R11: With `free_run_i` high and each word accepted at once, conversions start every `SPACING_CYC` cycles exactly, without `start_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle conversion request |
| free_run_i | input | 1 | Start conversions back to back at the minimum spacing |
| cs_no | output | 1 | Converter chip-select, active low |
| rc_o | output | 1 | Read (high) / convert (low) strobe |
| byte_sel_o | output | 1 | 0 selects result bits 15..8, 1 selects bits 7..0 |
| busy_i | input | 1 | Converter BUSY, low while converting |
| data_i | input | BYTE_W | Converter byte port |
| word_o | output | 2*BYTE_W | Assembled two's-complement result |
| valid_o | output | 1 | Result pending |
| ready_i | input | 1 | Result accepted when high with valid_o |
| err_o | output | 1 | One-cycle BUSY timeout pulse |

## Verification
The bench drives the controller against a behavioural converter that returns a filler byte until its access delay has passed. The result codes 7FFF, 8000, 0000, FFFF, 1234, A55A and a stepped sequence therefore separate a swapped byte order, a byte sampled too early and a lost sign bit. Single requests, free-running back-to-back conversions and a consumer that withholds ready for thousands of cycles show apart exact spacing, back-pressure and remembered requests. A silent converter exercises the timeout path. A second instance with split chip-select is compared on the number of read strobes per word.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CV_SETUP,
    ST_CV_PULSE,
    ST_WAIT_LOW,
    ST_WAIT_HIGH,
    ST_RD_HI,
    ST_RD_GAP,
    ST_RD_LO
  } rd_state_e;
endpackage

// File: rtl/adc_rd_timer.sv
module adc_rd_timer #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o
);
  // saturating up-counter, cleared on request
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_o <= '0;
    else if (clr_i)         cnt_o <= '0;
    else if (cnt_o != '1)   cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/adc_rd_pacer.sv
module adc_rd_pacer #(
  parameter int SPACING_CYC = 500
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic launch_i,
  output logic ok_o
);
  localparam int SP_W = $clog2(SPACING_CYC + 1);
  localparam logic [SP_W-1:0] SP_LAST = SP_W'(SPACING_CYC - 1);

  logic [SP_W-1:0] cnt_q;

  // cnt_q is 0 in the first pulse cycle; launch allowed once it reaches SP_LAST
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= SP_LAST;
    else if (launch_i)         cnt_q <= '0;
    else if (cnt_q < SP_LAST)  cnt_q <= cnt_q + 1'b1;
  end

  assign ok_o = (cnt_q == SP_LAST);
endmodule

// File: rtl/adc_rd_word.sv
module adc_rd_word #(
  parameter int BYTE_W = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cap_hi_i,
  input  logic                  cap_lo_i,
  input  logic [BYTE_W-1:0]     data_i,
  input  logic                  ready_i,
  output logic [2*BYTE_W-1:0]   word_o,
  output logic                  valid_o
);
  logic [BYTE_W-1:0] hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q    <= '0;
      word_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      if (cap_hi_i) hi_q <= data_i;
      if (cap_lo_i) begin
        word_o  <= {hi_q, data_i};
        valid_o <= 1'b1;
      end else if (valid_o && ready_i) begin
        valid_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/adc_byte_reader.sv
module adc_byte_reader
  import adc_rd_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int PULSE_CYC   = 3,
  parameter int SETUP_CYC   = 1,
  parameter int ACCESS_CYC  = 5,
  parameter int SPACING_CYC = 500,
  parameter int TIMEOUT_CYC = 1000,
  parameter int SYNC_STAGES = 2,
  parameter bit CS_SPLIT    = 1'b0
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic                free_run_i,
  output logic                cs_no,
  output logic                rc_o,
  output logic                byte_sel_o,
  input  logic                busy_i,
  input  logic [BYTE_W-1:0]   data_i,
  output logic [2*BYTE_W-1:0] word_o,
  output logic                valid_o,
  input  logic                ready_i,
  output logic                err_o
);
  localparam int TMR_MAX0 = (PULSE_CYC > SETUP_CYC) ? PULSE_CYC : SETUP_CYC;
  localparam int TMR_MAX  = (TMR_MAX0 > ACCESS_CYC) ? TMR_MAX0 : ACCESS_CYC;
  localparam int TMR_W    = $clog2(TMR_MAX + 1);
  localparam int WAIT_W   = $clog2(TIMEOUT_CYC + 1);
  localparam logic [TMR_W-1:0]  PULSE_LAST  = TMR_W'(PULSE_CYC - 1);
  localparam logic [TMR_W-1:0]  SETUP_LAST  = TMR_W'(SETUP_CYC - 1);
  localparam logic [TMR_W-1:0]  ACCESS_LAST = TMR_W'(ACCESS_CYC - 1);
  localparam logic [WAIT_W-1:0] WAIT_LAST   = WAIT_W'(TIMEOUT_CYC - 1);

  rd_state_e st_q, st_d;
  logic [TMR_W-1:0]       tmr;
  logic [WAIT_W-1:0]      wait_cnt;
  logic [SYNC_STAGES-1:0] busy_sync_q;
  logic busy_s, req_q, err_q;
  logic launch, cap_hi, cap_lo, to_evt, req_take, spc_ok, in_wait;

  // BUSY comes from another clock domain
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) busy_sync_q <= '1;
    else         busy_sync_q <= {busy_sync_q[SYNC_STAGES-2:0], busy_i};
  end
  assign busy_s = busy_sync_q[SYNC_STAGES-1];

  assign in_wait = (st_q == ST_WAIT_LOW) || (st_q == ST_WAIT_HIGH);

  adc_rd_timer #(.W(TMR_W)) u_st_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(st_d != st_q), .cnt_o(tmr)
  );

  adc_rd_timer #(.W(WAIT_W)) u_wait_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(!in_wait), .cnt_o(wait_cnt)
  );

  adc_rd_pacer #(.SPACING_CYC(SPACING_CYC)) u_pacer (
    .clk_i(clk_i), .rst_ni(rst_ni), .launch_i(launch), .ok_o(spc_ok)
  );

  adc_rd_word #(.BYTE_W(BYTE_W)) u_word (
    .clk_i(clk_i), .rst_ni(rst_ni), .cap_hi_i(cap_hi), .cap_lo_i(cap_lo),
    .data_i(data_i), .ready_i(ready_i), .word_o(word_o), .valid_o(valid_o)
  );

  always_comb begin
    st_d     = st_q;
    launch   = 1'b0;
    cap_hi   = 1'b0;
    cap_lo   = 1'b0;
    to_evt   = 1'b0;
    req_take = 1'b0;
    unique case (st_q)
      ST_IDLE: if ((req_q || free_run_i) && !valid_o) begin
        st_d     = ST_CV_SETUP;
        req_take = 1'b1;
      end
      // rc low, cs high: hold here until setup and spacing are both met
      ST_CV_SETUP: if (tmr >= SETUP_LAST && spc_ok) begin
        st_d   = ST_CV_PULSE;
        launch = 1'b1;
      end
      ST_CV_PULSE: if (tmr >= PULSE_LAST) st_d = ST_WAIT_LOW;
      ST_WAIT_LOW: begin
        if (!busy_s) st_d = ST_WAIT_HIGH;
        else if (wait_cnt >= WAIT_LAST) begin st_d = ST_IDLE; to_evt = 1'b1; end
      end
      ST_WAIT_HIGH: begin
        if (busy_s) st_d = ST_RD_HI;
        else if (wait_cnt >= WAIT_LAST) begin st_d = ST_IDLE; to_evt = 1'b1; end
      end
      ST_RD_HI: if (tmr >= ACCESS_LAST) begin
        cap_hi = 1'b1;
        st_d   = CS_SPLIT ? ST_RD_GAP : ST_RD_LO;
      end
      ST_RD_GAP: if (tmr >= SETUP_LAST) st_d = ST_RD_LO;
      ST_RD_LO: if (tmr >= ACCESS_LAST) begin
        cap_lo = 1'b1;
        st_d   = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      req_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      err_q <= to_evt;
      if (start_i)       req_q <= 1'b1;
      else if (req_take) req_q <= 1'b0;
    end
  end

  assign cs_no      = !((st_q == ST_CV_PULSE) || (st_q == ST_RD_HI) || (st_q == ST_RD_LO));
  assign rc_o       = !((st_q == ST_CV_SETUP) || (st_q == ST_CV_PULSE));
  assign byte_sel_o = (st_q == ST_RD_GAP) || (st_q == ST_RD_LO);
  assign err_o      = err_q;
endmodule

// File: rtl/adc_byte_reader_chk.sv
module adc_byte_reader_chk #(
  parameter int BYTE_W      = 8,
  parameter int PULSE_CYC   = 3,
  parameter int SPACING_CYC = 500,
  parameter bit CS_SPLIT    = 1'b0
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                cs_no,
  input logic                rc_o,
  input logic                byte_sel_o,
  input logic                busy_i,
  input logic [2*BYTE_W-1:0] word_o,
  input logic                valid_o,
  input logic                ready_i,
  input logic                err_o
);
  localparam int GAP_W = $clog2(SPACING_CYC + 1);
  localparam logic [GAP_W-1:0] GAP_V   = GAP_W'(SPACING_CYC);
  localparam logic [15:0]      PULSE_V = 16'(PULSE_CYC);

  logic [GAP_W-1:0] gap_q;
  logic [15:0]      pulse_q;
  logic             cs_prev_q, conv_start, both_low;

  assign both_low   = !cs_no && !rc_o;
  assign conv_start = cs_prev_q && both_low;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q     <= GAP_V;
      pulse_q   <= '0;
      cs_prev_q <= 1'b1;
    end else begin
      cs_prev_q <= cs_no;
      if (conv_start)          gap_q <= GAP_W'(1);
      else if (gap_q < GAP_V)  gap_q <= gap_q + 1'b1;
      if (!both_low)           pulse_q <= '0;
      else if (pulse_q != '1)  pulse_q <= pulse_q + 1'b1;
    end
  end

  assert_conv_pulse_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!both_low && pulse_q != '0) |-> pulse_q == PULSE_V);

  assert_rc_setup_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_no) |-> $stable(rc_o) && $stable(byte_sel_o));

  assert_release_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> cs_no && rc_o);

  assert_spacing_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start |-> gap_q >= GAP_V);

  assert_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i) |=> valid_o && $stable(word_o));

  assert_no_start_pending_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start |-> !valid_o);

  assert_err_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> cs_no && rc_o && !valid_o);

  assert_err_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !err_o);

  generate
    if (CS_SPLIT) begin : g_split
      assert_split_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $changed(byte_sel_o) |-> cs_no);
    end else begin : g_joined
      assert_joined_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(byte_sel_o) |-> !cs_no);
    end
  endgenerate
endmodule

bind adc_byte_reader adc_byte_reader_chk #(
  .BYTE_W(BYTE_W), .PULSE_CYC(PULSE_CYC), .SPACING_CYC(SPACING_CYC), .CS_SPLIT(CS_SPLIT)
) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .cs_no(cs_no), .rc_o(rc_o), .byte_sel_o(byte_sel_o),
  .busy_i(busy_i), .word_o(word_o), .valid_o(valid_o), .ready_i(ready_i), .err_o(err_o)
);

// File: tb/adc_byte_reader_tb_top.sv
`timescale 1ns/1ps

module adc_byte_reader_tb_model #(
  parameter int CONV_T   = 400,
  parameter int ACC_T    = 3,
  parameter int BUSY_DLY = 2
) (
  input  logic        clk,
  input  logic        cs_n,
  input  logic        rc,
  input  logic        bsel,
  input  logic        mute,
  input  logic [15:0] next_code,
  output logic        busy,
  output logic [7:0]  data,
  output logic        conv_start
);
  int          phase = 0;
  int          cnt   = 0;
  int          acc   = 0;
  logic [15:0] code_l = 16'h0;
  logic [15:0] result = 16'h0;
  logic        or_prev = 1'b1;
  logic        en_prev = 1'b0;
  logic        bsel_prev = 1'b0;
  logic        en;

  initial begin
    busy = 1'b1;
    conv_start = 1'b0;
  end

  assign en = !cs_n && rc;
  assign data = (en && en_prev && bsel == bsel_prev && acc >= ACC_T) ?
                (bsel ? result[7:0] : result[15:8]) : 8'h5A;

  always @(posedge clk) begin
    conv_start <= 1'b0;
    if (!(cs_n | rc) && or_prev && phase == 0 && busy && !mute) begin
      phase <= 1; cnt <= 0; code_l <= next_code; conv_start <= 1'b1;
    end else if (phase == 1) begin
      cnt <= cnt + 1;
      if (cnt + 1 == BUSY_DLY) begin busy <= 1'b0; phase <= 2; cnt <= 0; end
    end else if (phase == 2) begin
      cnt <= cnt + 1;
      if (cnt + 1 == CONV_T) begin result <= code_l; busy <= 1'b1; phase <= 0; end
    end
    or_prev <= cs_n | rc;
    if (en && (!en_prev || bsel != bsel_prev)) acc <= 0;
    else if (acc < ACC_T) acc <= acc + 1;
    en_prev   <= en;
    bsel_prev <= bsel;
  end
endmodule

module adc_byte_reader_tb_top;
  localparam int PULSE   = 3;
  localparam int SPACING = 500;
  localparam int TIMEOUT = 1000;
  localparam int LIMIT   = 150000;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #10 clk = ~clk;

  logic start0 = 0, start1 = 0, free_run = 0, ready0 = 0, ready1 = 0, mute = 0;
  logic [15:0] next_code0 = 16'h0, next_code1 = 16'h0;
  logic cs0, rc0, bs0, busy0, valid0, err0, cst0;
  logic cs1, rc1, bs1, busy1, valid1, err1, cst1;
  logic [7:0]  d0, d1;
  logic [15:0] w0, w1;

  adc_byte_reader dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start0), .free_run_i(free_run),
    .cs_no(cs0), .rc_o(rc0), .byte_sel_o(bs0), .busy_i(busy0), .data_i(d0),
    .word_o(w0), .valid_o(valid0), .ready_i(ready0), .err_o(err0)
  );
  adc_byte_reader_tb_model m0 (
    .clk(clk), .cs_n(cs0), .rc(rc0), .bsel(bs0), .mute(mute), .next_code(next_code0),
    .busy(busy0), .data(d0), .conv_start(cst0)
  );

  adc_byte_reader #(.CS_SPLIT(1'b1)) dut_split_i (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start1), .free_run_i(1'b0),
    .cs_no(cs1), .rc_o(rc1), .byte_sel_o(bs1), .busy_i(busy1), .data_i(d1),
    .word_o(w1), .valid_o(valid1), .ready_i(ready1), .err_o(err1)
  );
  adc_byte_reader_tb_model m1 (
    .clk(clk), .cs_n(cs1), .rc(rc1), .bsel(bs1), .mute(1'b0), .next_code(next_code1),
    .busy(busy1), .data(d1), .conv_start(cst1)
  );

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // reference monitor for dut_i, evaluated every clock away from the edge
  logic [15:0] exp_q[$];
  logic [15:0] exp_w, prev_w = 16'h0;
  logic prev_cs = 1, prev_rc = 1, prev_busy = 1, prev_valid = 0, prev_ready = 0, prev_low = 0;
  logic prev_cs1 = 1;
  int   pulse_n = 0, last_start = 0, rel_cyc = 0;
  int   conv_n = 0, err_n = 0, rd_falls0 = 0, rd_falls1 = 0;
  bit   have_start = 0, fr_exact = 0, auto_inc = 0;

  always @(negedge clk) begin
    cyc++;
    if (rst_ni) begin
      if (!cs0 && !rc0) pulse_n++;
      else if (pulse_n != 0) begin
        chk(pulse_n == PULSE, "R1", "convert pulse cycles", pulse_n, PULSE);
        pulse_n = 0;
      end
      if (prev_low && !(!cs0 && !rc0)) rel_cyc = cyc;
      if (!cs0 && prev_cs) begin
        chk(rc0 == prev_rc, "R2", "rc changed at cs fall", rc0, prev_rc);
        if (!rc0) begin
          if (have_start) begin
            chk(cyc - last_start >= SPACING, "R4", "start spacing", cyc - last_start, SPACING);
            if (fr_exact) chk(cyc - last_start == SPACING, "R11", "free-run period", cyc - last_start, SPACING);
          end
          chk(!prev_valid, "R7", "start while word pending", prev_valid, 0);
          last_start = cyc;
          have_start = 1;
        end else rd_falls0++;
      end
      if (busy0 && !prev_busy) chk(cs0 && rc0, "R3", "cs/rc low at busy rise", {cs0, rc0}, 2'b11);
      if (cst0) begin
        exp_q.push_back(next_code0);
        conv_n++;
        if (auto_inc) next_code0 = next_code0 + 16'h1357;
      end
      if (prev_valid && !prev_ready)
        chk(valid0 && w0 == prev_w, "R6", "held word", w0, prev_w);
      if (valid0 && ready0) begin
        if (exp_q.size() == 0) chk(0, "R6", "unexpected word", w0, 0);
        else begin
          exp_w = exp_q.pop_front();
          chk(w0 == exp_w, "R5", "assembled word", w0, exp_w);
        end
      end
      if (err0) begin
        err_n++;
        chk(cyc - rel_cyc == TIMEOUT, "R8", "timeout latency", cyc - rel_cyc, TIMEOUT);
      end
      if (!cs1 && prev_cs1 && rc1) rd_falls1++;
    end
    prev_cs = cs0; prev_rc = rc0; prev_busy = busy0; prev_valid = valid0;
    prev_ready = ready0; prev_w = w0; prev_low = !cs0 && !rc0; prev_cs1 = cs1;
    if (cyc > LIMIT && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, LIMIT);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic pulse_start0();
    tick(); start0 = 1; tick(); start0 = 0;
  endtask

  task automatic wait_valid0(input int lim);
    for (int i = 0; i < lim && !valid0; i++) @(negedge clk);
  endtask

  task automatic accept0();
    tick(); ready0 = 1; tick(); ready0 = 0;
  endtask

  task automatic do_conv(input logic [15:0] code);
    next_code0 = code;
    pulse_start0();
    wait_valid0(3000);
    chk(valid0, "R5", "word delivered", valid0, 1);
    accept0();
  endtask

  int n0, f0, e0;
  logic [15:0] held;

  initial begin
    repeat (3) @(negedge clk);
    chk(cs0 && rc0, "R10", "cs/rc in reset", {cs0, rc0}, 2'b11);
    chk(!bs0, "R10", "byte_sel in reset", bs0, 0);
    chk(!valid0 && !err0, "R10", "valid/err in reset", {valid0, err0}, 0);
    tick(); rst_ni = 1;

    // R5/R6: byte order and sign handling over edge codes
    do_conv(16'h7FFF);
    do_conv(16'h8000);
    do_conv(16'h0000);
    do_conv(16'hFFFF);
    f0 = rd_falls0;
    do_conv(16'h1234);
    chk(rd_falls0 - f0 == 1, "R9", "read strobes joined", rd_falls0 - f0, 1);
    do_conv(16'hA55A);

    // R7: back-pressure blocks conversions, even in free-run
    next_code0 = 16'h0F0E;
    pulse_start0();
    wait_valid0(3000);
    held = w0;
    n0 = conv_n;
    tick(); free_run = 1;
    repeat (2000) @(negedge clk);
    chk(valid0 && w0 == held, "R7", "word held under back-pressure", w0, held);
    chk(conv_n == n0, "R7", "conversions while pending", conv_n, n0);

    // R11: free-run at exact spacing
    auto_inc = 1;
    next_code0 = 16'h2468;
    tick(); ready0 = 1;
    for (int i = 0; i < 2000 && conv_n == n0; i++) @(negedge clk);
    fr_exact = 1;
    n0 = conv_n;
    for (int i = 0; i < 3000 && conv_n < n0 + 3; i++) @(negedge clk);
    chk(conv_n == n0 + 3, "R11", "free-run starts", conv_n - n0, 3);
    tick(); free_run = 0; fr_exact = 0; auto_inc = 0;
    for (int i = 0; i < 3000 && (exp_q.size() != 0 || valid0); i++) @(negedge clk);
    tick(); ready0 = 0;

    // R7: a start during a pending word is remembered
    next_code0 = 16'h00FF;
    pulse_start0();
    wait_valid0(3000);
    n0 = conv_n;
    next_code0 = 16'hFF00;
    pulse_start0();
    repeat (700) @(negedge clk);
    chk(conv_n == n0, "R7", "start while pending", conv_n, n0);
    accept0();
    for (int i = 0; i < 1000 && conv_n == n0; i++) @(negedge clk);
    chk(conv_n == n0 + 1, "R7", "remembered start", conv_n, n0 + 1);
    wait_valid0(3000);
    accept0();

    // R8: silent converter
    mute = 1;
    e0 = err_n;
    pulse_start0();
    for (int i = 0; i < 2500 && err_n == e0; i++) @(negedge clk);
    chk(err_n == e0 + 1, "R8", "timeout pulses", err_n - e0, 1);
    repeat (20) @(negedge clk);
    chk(!valid0 && err_n == e0 + 1, "R8", "no word after timeout", valid0, 0);
    mute = 0;
    do_conv(16'h4321);

    // R9: split chip-select instance
    next_code1 = 16'hBEEF;
    f0 = rd_falls1;
    tick(); start1 = 1; tick(); start1 = 0;
    for (int i = 0; i < 3000 && !valid1; i++) @(negedge clk);
    chk(valid1 && w1 == 16'hBEEF, "R9", "split word", w1, 16'hBEEF);
    chk(rd_falls1 - f0 == 2, "R9", "read strobes split", rd_falls1 - f0, 2);
    tick(); ready1 = 1; tick(); ready1 = 0;

    repeat (10) @(negedge clk);
    chk(exp_q.size() == 0, "R6", "words left undelivered", exp_q.size(), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule